// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This unit watches a running BCD calendar and raises an alarm when the time of day or date reaches a programmed value. Six alarm value registers hold a target for seconds, minutes, hours, day of month, month and year. A control register selects which of those fields take part in the comparison and carries a global enable. Each stored value is trimmed to the width its field needs when it is written.

The calendar sits outside this unit. It presents its fields in BCD together with a one-cycle strobe in the cycle after each one-second advance. Only in a strobe cycle does the unit compare the enabled fields against their alarm values. If any enabled field matches, the unit sets a sticky pending flag and drives the alarm interrupt. It does not require every enabled field to match. Software clears the flag by writing a 1 to it.

Registers use a plain single-cycle write port and a combinational read port, both addressed by a 3-bit index. The map is: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 month, 6 year, 7 status. No data stream passes through the block, so none of its pins uses a valid/ready handshake.

Top module: `cal_alarm`

## Requirements
- R1: After reset every register reads 0, and `alarm_pending` and `alarm_irq` are low.
- R2: Writes are trimmed to the field width before storage. Seconds and minutes keep 7 bits, hours and day keep 6, month keeps 5, year keeps 12, and control keeps 7. A read returns the trimmed value.
- R3: Control bits 0 to 5 enable seconds, minutes, hours, day, month and year, in that order. A field whose bit is 0 never causes an alarm, even when it matches.
- R4: While control bit 6 is 0, no alarm is raised, whatever the field enables and matches are.
- R5: With bit 6 set, an alarm is raised when at least one enabled field equals its alarm register.
- R6: Comparison takes place only in a cycle where `sec_tick` is high. Matching values without the strobe raise nothing.
- R7: The year is compared as a 12-bit, 3-digit BCD value: tens and units in bits [7:0] and the hundreds digit in bits [11:8]. A difference in the hundreds digit alone means no match.
- R8: The month is compared in the same 1-based BCD form that the calendar presents (01 to 12).
- R9: A hit in a strobe cycle sets status bit 1 and asserts `alarm_irq` at the next clock edge. Both stay set through later strobes with no match.
- R10: A status write with bit 1 set clears the flag and the interrupt. A write with bit 1 at 0 has no effect. A hit in the same cycle as a clear wins.
- R11: A strobe on which several fields match produces one event. After a clear, the flag stays low until the next matching strobe, even while the calendar still matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe after each calendar advance |
| cal_sec | input | 7 | Calendar seconds, BCD |
| cal_min | input | 7 | Calendar minutes, BCD |
| cal_hour | input | 6 | Calendar hours, BCD |
| cal_day | input | 6 | Calendar day of month, BCD |
| cal_mon | input | 5 | Calendar month, BCD, 1-based |
| cal_year | input | 12 | Calendar year, 3-digit BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write index |
| wr_data | input | 12 | Register write data |
| rd_addr | input | 3 | Register read index |
| rd_data | output | 12 | Register read data, combinational |
| alarm_pending | output | 1 | Sticky alarm flag (status bit 1) |
| alarm_irq | output | 1 | Alarm interrupt line |

## Verification
A wrongly trimmed or wrongly addressed alarm register shows at the read port in the cycle after the write. It also shows as a missed or spurious alarm at the first strobe that compares that field. A wrong enable mapping or combining rule shows at `alarm_pending` one edge after a strobe. The directed scenarios set exactly one matching field, several matching fields, or a matching field that is disabled, so that such a fault changes the flag at once. Faults in the sticky flag show as a flag that drops during quiet strobes, ignores a clear, or loses an event that coincides with a clear.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int VAL_W      = 12;
  localparam int CTRL_W     = 7;
  localparam int ADDR_W     = 3;
  localparam int GLOBAL_BIT = 6;
  localparam int PEND_BIT   = 1;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd7;

  typedef logic [NUM_FIELDS-1:0][VAL_W-1:0] field_vec_t;

  // stored width of each alarm field, index 0 = seconds .. 5 = year
  function automatic logic [VAL_W-1:0] field_mask(input int idx);
    case (idx)
      0, 1:    field_mask = 12'h07F;
      2, 3:    field_mask = 12'h03F;
      4:       field_mask = 12'h01F;
      default: field_mask = 12'hFFF;
    endcase
  endfunction
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [VAL_W-1:0]        wr_data,
  output logic [CTRL_W-1:0]       ctrl_q,
  output field_vec_t              alm_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en && wr_addr == ADDR_CTRL) ctrl_q <= wr_data[CTRL_W-1:0];
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i + 1);
    localparam logic [VAL_W-1:0]  MY_MASK = field_mask(i);

    always_ff @(posedge clk) begin
      if (!rst_n) alm_q[i] <= '0;
      else if (wr_en && wr_addr == MY_ADDR) alm_q[i] <= wr_data & MY_MASK;
    end

    assert_trimmed_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == MY_ADDR) |=> (alm_q[i] & ~MY_MASK) == '0);
  end

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
(
  input  logic                  tick,
  input  logic                  global_en,
  input  logic [NUM_FIELDS-1:0] field_en,
  input  field_vec_t            cal_val,
  input  field_vec_t            alm_val,
  output logic                  hit
);

  logic [NUM_FIELDS-1:0] field_eq;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
    assign field_eq[i] = field_en[i] && (cal_val[i] == alm_val[i]);
  end

  // one hit per strobe regardless of how many fields agree
  assign hit = tick && global_en && (|field_eq);

endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assert_set_on_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);

endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
  import cal_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [6:0]        cal_sec,
  input  logic [6:0]        cal_min,
  input  logic [5:0]        cal_hour,
  input  logic [5:0]        cal_day,
  input  logic [4:0]        cal_mon,
  input  logic [11:0]       cal_year,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [11:0]       wr_data,
  input  logic [2:0]        rd_addr,
  output logic [11:0]       rd_data,
  output logic              alarm_pending,
  output logic              alarm_irq
);

  logic [CTRL_W-1:0] ctrl_q;
  field_vec_t        alm_q;
  field_vec_t        cal_vec;
  logic              hit;
  logic              clr;

  assign cal_vec[0] = VAL_W'(cal_sec);
  assign cal_vec[1] = VAL_W'(cal_min);
  assign cal_vec[2] = VAL_W'(cal_hour);
  assign cal_vec[3] = VAL_W'(cal_day);
  assign cal_vec[4] = VAL_W'(cal_mon);
  assign cal_vec[5] = cal_year;

  cal_alarm_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q),
    .alm_q   (alm_q)
  );

  cal_alarm_match u_match (
    .tick      (sec_tick),
    .global_en (ctrl_q[GLOBAL_BIT]),
    .field_en  (ctrl_q[NUM_FIELDS-1:0]),
    .cal_val   (cal_vec),
    .alm_val   (alm_q),
    .hit       (hit)
  );

  assign clr = wr_en && (wr_addr == ADDR_STATUS) && wr_data[PEND_BIT];

  cal_alarm_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (hit),
    .clr_i  (clr),
    .flag_q (alarm_pending)
  );

  assign alarm_irq = alarm_pending;

  always_comb begin
    if (rd_addr == ADDR_CTRL)        rd_data = VAL_W'(ctrl_q);
    else if (rd_addr == ADDR_STATUS) rd_data = VAL_W'({alarm_pending, 1'b0});
    else                             rd_data = alm_q[rd_addr - 3'd1];
  end

  assert_rise_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_pending) |-> $past(sec_tick));
  assert_rise_needs_global_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_pending) |-> $past(ctrl_q[GLOBAL_BIT]));
  assert_rise_needs_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_pending) |-> ($past(ctrl_q[NUM_FIELDS-1:0]) != '0));

endmodule

// File: tb/tb_cal_alarm.sv
module tb_cal_alarm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0;
  logic [6:0]  cal_sec = '0;
  logic [6:0]  cal_min = '0;
  logic [5:0]  cal_hour = '0;
  logic [5:0]  cal_day = '0;
  logic [4:0]  cal_mon = '0;
  logic [11:0] cal_year = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [11:0] rd_data;
  logic        alarm_pending, alarm_irq;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cal_alarm dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_flag(input string req, input bit exp);
    check(alarm_pending == exp && alarm_irq == exp, req, {alarm_irq, alarm_pending}, {exp, exp});
  endtask

  task automatic check_reg(input string req, input logic [2:0] a, input logic [11:0] exp);
    rd_addr = a;
    #1;
    check(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [11:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic set_cal(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                         input logic [5:0] d, input logic [4:0] mo, input logic [11:0] y);
    cal_sec = s; cal_min = m; cal_hour = h; cal_day = d; cal_mon = mo; cal_year = y;
  endtask

  task automatic set_baseline();
    set_cal(7'h01, 7'h02, 6'h03, 6'h04, 5'h05, 12'h024);
  endtask

  task automatic set_all_match();
    set_cal(7'h30, 7'h45, 6'h07, 6'h15, 5'h09, 12'h123);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) check_reg("R1 reg reset", 3'(a), 12'h000);
    check_flag("R1 flag reset", 1'b0);
  endtask

  task automatic t_masking();
    for (int a = 0; a < 7; a++) reg_write(3'(a), 12'hFFF);
    check_reg("R2 ctrl trim", 3'd0, 12'h07F);
    check_reg("R2 sec trim", 3'd1, 12'h07F);
    check_reg("R2 min trim", 3'd2, 12'h07F);
    check_reg("R2 hour trim", 3'd3, 12'h03F);
    check_reg("R2 day trim", 3'd4, 12'h03F);
    check_reg("R2 month trim", 3'd5, 12'h01F);
    check_reg("R2 year trim", 3'd6, 12'hFFF);
    reg_write(3'd0, 12'h000);
    reg_write(3'd1, 12'h030);
    reg_write(3'd2, 12'h045);
    reg_write(3'd3, 12'h007);
    reg_write(3'd4, 12'h015);
    reg_write(3'd5, 12'h009);
    reg_write(3'd6, 12'h123);
    check_reg("R2 sec value", 3'd1, 12'h030);
  endtask

  task automatic t_gating();
    set_all_match();
    reg_write(3'd0, 12'h03F);
    tick();
    check_flag("R4 global enable low blocks alarm", 1'b0);
    reg_write(3'd0, 12'h040);
    tick();
    check_flag("R3 no field enabled blocks alarm", 1'b0);
  endtask

  task automatic t_field_enable();
    set_baseline();
    cal_sec = 7'h30;
    reg_write(3'd0, 12'h042);
    tick();
    check_flag("R3 disabled seconds match ignored", 1'b0);
    cal_min = 7'h45;
    tick();
    check_flag("R3 enabled minutes match fires", 1'b1);
    reg_write(3'd7, 12'h002);
    check_flag("R10 clear", 1'b0);
  endtask

  task automatic t_any_match();
    set_baseline();
    cal_hour = 6'h07;
    reg_write(3'd0, 12'h07F);
    tick();
    check_flag("R5 single enabled match fires", 1'b1);
    check_reg("R9 status bit 1 set", 3'd7, 12'h002);
    set_baseline();
    tick();
    tick();
    check_flag("R9 sticky through quiet strobes", 1'b1);
    reg_write(3'd7, 12'hFFD);
    check_flag("R10 write with bit1 zero ignored", 1'b1);
    reg_write(3'd7, 12'h002);
    check_flag("R10 write one clears", 1'b0);
    check_reg("R10 status reads zero", 3'd7, 12'h000);
  endtask

  task automatic t_no_tick();
    set_all_match();
    repeat (5) @(negedge clk);
    check_flag("R6 no strobe no alarm", 1'b0);
    tick();
    check_flag("R11 multi-field match fires", 1'b1);
    reg_write(3'd7, 12'h002);
    repeat (4) @(negedge clk);
    check_flag("R11 single event, no refire without strobe", 1'b0);
  endtask

  task automatic t_year();
    set_baseline();
    cal_year = 12'h023;
    reg_write(3'd0, 12'h060);
    tick();
    check_flag("R7 hundreds digit differs", 1'b0);
    cal_year = 12'h123;
    tick();
    check_flag("R7 full 3-digit match", 1'b1);
    reg_write(3'd7, 12'h002);
  endtask

  task automatic t_month();
    set_baseline();
    cal_mon = 5'h08;
    reg_write(3'd0, 12'h050);
    tick();
    check_flag("R8 other month", 1'b0);
    cal_mon = 5'h09;
    tick();
    check_flag("R8 one-based month match", 1'b1);
    reg_write(3'd7, 12'h002);
  endtask

  task automatic t_set_beats_clear();
    set_all_match();
    reg_write(3'd0, 12'h07F);
    @(negedge clk);
    sec_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd7; wr_data = 12'h002;
    @(negedge clk);
    sec_tick = 1'b0; wr_en = 1'b0;
    check_flag("R10 hit wins over clear", 1'b1);
  endtask

  initial begin
    set_baseline();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masking();
    t_gating();
    t_field_enable();
    t_any_match();
    t_no_tick();
    t_year();
    t_month();
    t_set_beats_clear();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule